// File: doc/BRIEF.md
# 16-bit Shift and Rotate Unit

This block moves the bits of a 16-bit word by 0 to 15 positions in one of seven ways: arithmetic or logical right shift, logical left shift, and rotates in both directions. The rotates come in two kinds. One kind wraps the word around on itself. The other passes the word through a carry bit, and that kind always moves by exactly one position. It is the shift section of a datapath unit. Each cycle it takes an operand word, a 4-bit distance, a 3-bit operation code and a carry bit. One clock later it presents the moved word and a carry bit.

Every operation runs through the same right-moving network. That network has four conditional stages, which move by 1, 2, 4 and 8 positions. A fill table sits beside the network and decides what enters at the top when bits fall off the bottom: copies of the sign bit, zeros, the word itself, or the carry-in. For the left-direction operations the word is mirrored before the network and mirrored again after it.

Top module: `shift_rotate_unit`

## Requirements
- R1: While `rst_n` is low, `result_o` and `carry_o` are 0. After reset, both outputs show the outcome of the inputs that were present at the previous rising clock edge.
- R2: Code 0 is an arithmetic right shift by `amt_i`. The vacated upper positions take the value of bit 15. `carry_o` is input bit `amt_i-1`, or 0 when the distance is 0.
- R3: Code 1 is a logical right shift by `amt_i`. The vacated upper positions are 0. `carry_o` is input bit `amt_i-1`, or 0 when the distance is 0.
- R4: Code 2 is a logical left shift by `amt_i`. The vacated lower positions are 0. `carry_o` is input bit `16-amt_i`, or 0 when the distance is 0.
- R5: Code 3 rotates right by `amt_i`. Bits leaving position 0 re-enter at position 15. `carry_o` is input bit `amt_i-1`, or 0 when the distance is 0.
- R6: Code 4 rotates left by `amt_i`. Bits leaving position 15 re-enter at position 0. `carry_o` is input bit `16-amt_i`, or 0 when the distance is 0.
- R7: Code 5 rotates right by one through the carry. `result_o` is `{cin_i, data_i[15:1]}` and `carry_o` is `data_i[0]`, whatever the value of `amt_i`.
- R8: Code 6 rotates left by one through the carry. `result_o` is `{data_i[14:0], cin_i}` and `carry_o` is `data_i[15]`, whatever the value of `amt_i`.
- R9: Code 7 is unassigned. It returns `data_i` unchanged with `carry_o` equal to 0, whatever the values of `amt_i` and `cin_i`.
- R10: For codes 0 to 4 with a distance of 0, the word comes out unchanged, `carry_o` is 0, and `cin_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_i | input | 16 | Operand word |
| amt_i | input | 4 | Shift or rotate distance |
| op_i | input | 3 | Operation code (0 to 7) |
| cin_i | input | 1 | Carry input for the rotates through carry |
| result_o | output | 16 | Moved word, registered |
| carry_o | output | 1 | Carry output, registered |

## Verification
The hardest case to reach from the ports is a rotate through carry requested with a distance other than one. Here the requested distance has to be overridden, and the carry-in, rather than a data bit, has to land in the vacated position. The stimulus drives both carry codes with every distance from 0 to 15, using both carry-in values and opposing data patterns. This way a forgotten override or a wrong fill bit changes the result visibly. The left operations at distance 15 get the same treatment, because their carry comes from bit 1 and would expose a mistake in the mirroring.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [2:0] {
    SHF_ASR  = 3'd0,
    SHF_LSR  = 3'd1,
    SHF_LSL  = 3'd2,
    SHF_ROR  = 3'd3,
    SHF_ROL  = 3'd4,
    SHF_RORC = 3'd5,
    SHF_ROLC = 3'd6,
    SHF_PASS = 3'd7
  } shf_op_e;

endpackage

// File: rtl/shf_fill_table.sv
module shf_fill_table
  import shf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  shf_op_e           op,
  input  logic [DATA_W-1:0] data,
  input  logic [AMT_W-1:0]  amt,
  input  logic              cin,
  output logic [DATA_W-1:0] prim_data,
  output logic [DATA_W-1:0] prim_fill,
  output logic [AMT_W-1:0]  amt_eff,
  output logic              mirror
);

  logic [DATA_W-1:0] data_rev;

  // Mirrored copy of the operand, used by the left-direction operations.
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign data_rev[i] = data[DATA_W-1-i];
  end

  always_comb begin
    mirror    = 1'b0;
    prim_data = data;
    prim_fill = '0;
    amt_eff   = amt;
    unique case (op)
      SHF_ASR:  prim_fill = {DATA_W{data[DATA_W-1]}};
      SHF_LSR:  prim_fill = '0;
      SHF_LSL: begin
        mirror    = 1'b1;
        prim_data = data_rev;
      end
      SHF_ROR:  prim_fill = data;
      SHF_ROL: begin
        mirror    = 1'b1;
        prim_data = data_rev;
        prim_fill = data_rev;
      end
      SHF_RORC: begin
        prim_fill = {{(DATA_W-1){1'b0}}, cin};
        amt_eff   = AMT_W'(1);
      end
      SHF_ROLC: begin
        mirror    = 1'b1;
        prim_data = data_rev;
        prim_fill = {{(DATA_W-1){1'b0}}, cin};
        amt_eff   = AMT_W'(1);
      end
      default:  amt_eff = '0;
    endcase
  end

endmodule

// File: rtl/shf_stage.sv
module shf_stage #(
  parameter int EXT_W = 33,
  parameter int STEP  = 1
) (
  input  logic             en,
  input  logic [EXT_W-1:0] din,
  output logic [EXT_W-1:0] dout
);

  // One conditional right move of STEP positions; the fill bits ride above the word.
  assign dout = en ? (din >> STEP) : din;

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import shf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic [2:0]        op_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);

  // Layout of the bus through the stages: {fill, word, guard}.
  localparam int EXT_W = 2*DATA_W + 1;

  shf_op_e           op_e;
  logic [DATA_W-1:0] prim_data;
  logic [DATA_W-1:0] prim_fill;
  logic [AMT_W-1:0]  amt_eff;
  logic              mirror;
  logic [EXT_W-1:0]  stage_bus [AMT_W+1];
  logic [DATA_W-1:0] prim_out;
  logic [DATA_W-1:0] prim_out_rev;
  logic [DATA_W-1:0] unused_fill_tail;
  logic [DATA_W-1:0] result_d;
  logic              carry_d;
  logic [DATA_W-1:0] result_q;
  logic              carry_q;

  assign op_e = shf_op_e'(op_i);

  shf_fill_table #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_fill (
    .op        (op_e),
    .data      (data_i),
    .amt       (amt_i),
    .cin       (cin_i),
    .prim_data (prim_data),
    .prim_fill (prim_fill),
    .amt_eff   (amt_eff),
    .mirror    (mirror)
  );

  assign stage_bus[0] = {prim_fill, prim_data, 1'b0};

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    shf_stage #(.EXT_W(EXT_W), .STEP(1 << s)) u_stage (
      .en   (amt_eff[s]),
      .din  (stage_bus[s]),
      .dout (stage_bus[s+1])
    );
  end

  assign prim_out         = stage_bus[AMT_W][DATA_W:1];
  assign unused_fill_tail = stage_bus[AMT_W][EXT_W-1:DATA_W+1];

  for (genvar i = 0; i < DATA_W; i++) begin : g_unrev
    assign prim_out_rev[i] = prim_out[DATA_W-1-i];
  end

  // Next-state logic
  always_comb begin
    result_d = mirror ? prim_out_rev : prim_out;
    carry_d  = stage_bus[AMT_W][0];
  end

  // Output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      carry_q  <= 1'b0;
    end else begin
      result_q <= result_d;
      carry_q  <= carry_d;
    end
  end

  assign result_o = result_q;
  assign carry_o  = carry_q;

  // Checks on the registered outputs against the inputs of the previous cycle
  p_asr_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op_i) == 3'd0) |-> result_o[DATA_W-1] == $past(data_i[DATA_W-1]));

  p_lsr_top_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op_i) == 3'd1 && $past(amt_i) != '0) |-> !result_o[DATA_W-1]);

  p_lsl_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op_i) == 3'd2 && $past(amt_i) != '0) |-> !result_o[0]);

  p_ror_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op_i) == 3'd3) |-> $countones(result_o) == $countones($past(data_i)));

  p_rol_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op_i) == 3'd4) |-> $countones(result_o) == $countones($past(data_i)));

  p_rorc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op_i) == 3'd5) |->
      (result_o == {$past(cin_i), $past(data_i[DATA_W-1:1])} && carry_o == $past(data_i[0])));

  p_rolc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op_i) == 3'd6) |->
      (result_o == {$past(data_i[DATA_W-2:0]), $past(cin_i)} && carry_o == $past(data_i[DATA_W-1])));

  p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op_i) == 3'd7) |-> (result_o == $past(data_i) && !carry_o));

  p_zero_amt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op_i) <= 3'd4 && $past(amt_i) == '0) |->
      (result_o == $past(data_i) && !carry_o));

endmodule

// File: tb/shift_rotate_unit_tb.sv
`timescale 1ns/1ps
module shift_rotate_unit_tb;

  logic        clk;
  logic        rst_n;
  logic [15:0] data_i;
  logic [3:0]  amt_i;
  logic [2:0]  op_i;
  logic        cin_i;
  logic [15:0] result_o;
  logic        carry_o;

  int n_cmp  = 0;
  int n_fail = 0;

  shift_rotate_unit u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_i   (data_i),
    .amt_i    (amt_i),
    .op_i     (op_i),
    .cin_i    (cin_i),
    .result_o (result_o),
    .carry_o  (carry_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Reference written directly from the requirements
  function automatic logic [16:0] model(input logic [2:0] op, input logic [15:0] d,
                                        input int a, input logic c);
    logic [31:0] dd;
    logic [15:0] r;
    logic        co;
    dd = {d, d};
    co = 1'b0;
    case (op)
      3'd0: begin r = 16'($signed(d) >>> a); if (a > 0) co = d[a-1]; end
      3'd1: begin r = d >> a;                if (a > 0) co = d[a-1]; end
      3'd2: begin r = d << a;                if (a > 0) co = d[16-a]; end
      3'd3: begin r = 16'(dd >> a);          if (a > 0) co = d[a-1]; end
      3'd4: begin r = 16'((dd << a) >> 16);  if (a > 0) co = d[16-a]; end
      3'd5: begin r = {c, d[15:1]}; co = d[0]; end
      3'd6: begin r = {d[14:0], c}; co = d[15]; end
      default: r = d;
    endcase
    return {co, r};
  endfunction

  task automatic apply(input logic [2:0] op, input logic [15:0] d, input int a,
                       input logic c, input string req);
    logic [16:0] exp;
    @(negedge clk);
    op_i = op; data_i = d; amt_i = 4'(a); cin_i = c;
    exp = model(op, d, a, c);
    @(negedge clk);
    n_cmp++;
    if ({carry_o, result_o} !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d d=%h amt=%0d cin=%b: got c=%b r=%h exp c=%b r=%h",
               req, op, d, a, c, carry_o, result_o, exp[16], exp[15:0]);
    end
  endtask

  task automatic t_reset_r1();
    rst_n = 1'b0;
    op_i = 3'd3; data_i = 16'hFFFF; amt_i = 4'd3; cin_i = 1'b1;
    repeat (3) @(negedge clk);
    n_cmp++;
    if (result_o !== 16'h0 || carry_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: got c=%b r=%h exp c=0 r=0000", carry_o, result_o);
    end
    rst_n = 1'b1;
    apply(3'd1, 16'h8001, 1, 1'b0, "R1");
  endtask

  task automatic t_sweep(input logic [2:0] op, input string req);
    for (int a = 0; a < 16; a++) begin
      apply(op, 16'hB2C5, a, 1'b0, req);
      apply(op, 16'h4D3A, a, 1'b1, req);
    end
    apply(op, 16'h8000, 15, 1'b1, req);
    apply(op, 16'h0001, 15, 1'b0, req);
  endtask

  task automatic t_carry_rot(input logic [2:0] op, input string req);
    for (int a = 0; a < 16; a++) begin
      apply(op, 16'hA5F0, a, 1'b1, req);
      apply(op, 16'h5A0F, a, 1'b0, req);
    end
  endtask

  task automatic t_pass_r9();
    for (int a = 0; a < 16; a += 5) begin
      apply(3'd7, 16'hC3A1, a, 1'b1, "R9");
      apply(3'd7, 16'h0FF0, a, 1'b0, "R9");
    end
  endtask

  task automatic t_zero_amt_r10();
    for (int op = 0; op < 5; op++) begin
      apply(3'(op), 16'h9E37, 0, 1'b1, "R10");
      apply(3'(op), 16'h61C8, 0, 1'b0, "R10");
    end
  endtask

  initial begin
    op_i = '0; data_i = '0; amt_i = '0; cin_i = 1'b0; rst_n = 1'b0;
    t_reset_r1();
    t_sweep(3'd0, "R2");
    t_sweep(3'd1, "R3");
    t_sweep(3'd2, "R4");
    t_sweep(3'd3, "R5");
    t_sweep(3'd4, "R6");
    t_carry_rot(3'd5, "R7");
    t_carry_rot(3'd6, "R8");
    t_pass_r9();
    t_zero_amt_r10();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

endmodule